// File: doc/BRIEF.md
# Reload Timer Capture/Compare Unit

A single 16-bit timer counts upward and, after reaching all ones, restarts from a programmable reload value. Six channels share this timebase. Each channel is either idle, a compare channel that drives a pin output, or a capture channel that records the timer value when its pin input changes.

A compare channel drives its output to a chosen level when the timer equals the channel's compare value. On every overflow it returns the output to the opposite level. A new compare value can be held in a shadow register until the next overflow, or it can take effect at once. A capture channel synchronizes its pin through two flip-flops and detects rising edges, falling edges, or both. It can also be told by a register write to latch the live timer value.

Every match and every capture sets a sticky per-channel flag, and overflow sets its own sticky flag. Software clears these flags by writing ones to a clear register.

Top module: `reload_ccu`

## Requirements
- R1: The timer resets to 0, adds 1 each clock while the run bit (address 0, bit 0) is set, and holds its value while the run bit is clear. A write to address 15 loads the timer directly, and this load takes precedence over counting.
- R2: When the running timer equals 16'hFFFF, its next value is the reload value written at address 1. That cycle also sets the sticky overflow flag, which is cleared by writing 1 to bit 15 at address 14.
- R3: The channel configuration for channel k is at address 2+k: bits [1:0] mode (0 idle, 1 compare, 2 capture), bit 2 rising edge, bit 3 falling edge, bit 4 shadow enable, bit 5 match level. In compare mode, a match between the running timer and the channel's active compare value drives the output to the match level on the next clock. An overflow drives the output to the inverse level, and overflow takes priority over a match.
- R4: With shadow enable set, a compare value written to address 8+k goes only to a shadow register. The active compare value (shown on cc_val_o) and the output are unaffected until the next overflow, which copies the shadow into the active value.
- R5: With shadow enable clear, a compare write updates the active compare value on the next clock, so a match can occur within the same timer period.
- R6: A compare value below the reload value is never reached by the timer, so the output stays at the overflow level and the flag is never set.
- R7: In capture mode the pin input passes through two synchronizer flip-flops. A rising or falling transition, when enabled by bit 2 or bit 3 respectively, copies the timer value into cc_val_o. The value copied is the one present in the cycle the synchronized edge is seen, which is three clocks after the pin changes. Disabled edge directions capture nothing.
- R8: Writing a configuration word with bit 6 set is a soft capture. It copies the timer value of that write cycle into the channel register and sets the channel flag. Bit 6 itself is not stored.
- R9: Each channel's flag is set by its own match or capture and is cleared by writing 1 to bit k at address 14. Clearing one flag leaves the others unchanged, and a set in the same cycle as a clear takes precedence.
- R10: A channel in idle or capture mode keeps its pin output unchanged, including across overflows.
- R11: After reset all outputs, flags, compare and capture values are 0 and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| cc_pin_i | input | 6 | Capture pin inputs, one per channel |
| cc_pin_o | output | 6 | Compare outputs, one per channel |
| cc_val_o | output | 96 | Active compare or captured value, channel k at bits [16k+15:16k] |
| cc_flag_o | output | 6 | Sticky per-channel event flags |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| timer_o | output | 16 | Current timer value |

## Verification
The assertions check several properties on every cycle. The timer either increments, holds or wraps to the reload value. The overflow flag and a compare output follow overflow and match. An active compare value under shadowing stays still between overflows. Soft capture latches the live timer value and sets the flag, and a non-compare channel's output never changes. Only the scenarios can show the rest: the exact output waveform over whole timer periods at both match levels, the three-cycle latency from pin to captured value, the edge-direction selection, a compare value below reload never firing, and the independence of per-channel flag clearing.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_CMP = 2'd1,
    MODE_CAP = 2'd2,
    MODE_RSV = 2'd3
  } cc_mode_e;

  // packed: mode occupies bits [1:0]
  typedef struct packed {
    logic     match_lvl;
    logic     shadow_en;
    logic     edge_fall;
    logic     edge_rise;
    cc_mode_e mode;
  } cc_cfg_t;

  localparam int CFG_W    = 6;
  localparam int SOFT_BIT = 6;
endpackage

// File: rtl/ccu_timebase.sv
module ccu_timebase #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  assign ovf_o = run_i && !load_i && (cnt_q == TOP);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (ovf_o)  cnt_q <= reload_i;
    else if (run_i)  cnt_q <= cnt_q + ONE;
  end

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == $past(reload_i));
  assert_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + ONE);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
  import ccu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic [6:0]    cfg_data_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] cmp_data_i,
  input  logic          flag_clr_i,
  input  logic          run_i,
  input  logic          ovf_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pin_i,
  output logic          pin_o,
  output logic [CW-1:0] cc_o,
  output logic          flag_o
);
  cc_cfg_t       cfg_q;
  logic [2:0]    sync_q;
  logic [CW-1:0] shd_q, cc_q;
  logic          pin_q, flag_q;
  logic          is_cmp, is_cap, rise, fall, soft_cap, cap_ev, match;

  assign is_cmp   = (cfg_q.mode == MODE_CMP);
  assign is_cap   = (cfg_q.mode == MODE_CAP);
  assign rise     = sync_q[1] && !sync_q[2];
  assign fall     = !sync_q[1] && sync_q[2];
  assign soft_cap = cfg_wr_i && cfg_data_i[SOFT_BIT];
  assign cap_ev   = soft_cap ||
                    (is_cap && ((rise && cfg_q.edge_rise) || (fall && cfg_q.edge_fall)));
  assign match    = is_cmp && run_i && (cnt_i == cc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_i};
      if (cfg_wr_i) cfg_q <= cc_cfg_t'(cfg_data_i[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      cc_q  <= '0;
    end else begin
      if (cmp_wr_i) shd_q <= cmp_data_i;
      if (cap_ev)                           cc_q <= cnt_i;
      else if (cmp_wr_i && !cfg_q.shadow_en) cc_q <= cmp_data_i;
      else if (ovf_i && is_cmp)             cc_q <= shd_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (is_cmp) begin
        if (ovf_i)      pin_q <= !cfg_q.match_lvl;
        else if (match) pin_q <= cfg_q.match_lvl;
      end
      if (cap_ev || match) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign pin_o  = pin_q;
  assign cc_o   = cc_q;
  assign flag_o = flag_q;

  assert_ovf_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmp && ovf_i) |=> pin_q == !$past(cfg_q.match_lvl));
  assert_match_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmp && run_i && !ovf_i && cnt_i == cc_q) |=> pin_q == $past(cfg_q.match_lvl));
  assert_shadow_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmp && cfg_q.shadow_en && !ovf_i && !soft_cap) |=> $stable(cc_q));
  assert_soft_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_cap |=> (flag_q && cc_q == $past(cnt_i)));
  assert_idle_pin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_cmp |=> $stable(pin_q));
endmodule

// File: rtl/reload_ccu.sv
module reload_ccu #(
  parameter int NUM_CH = 6,
  parameter int CW     = 16,
  parameter int AW     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [CW-1:0]        wr_data_i,
  input  logic [NUM_CH-1:0]    cc_pin_i,
  output logic [NUM_CH-1:0]    cc_pin_o,
  output logic [NUM_CH*CW-1:0] cc_val_o,
  output logic [NUM_CH-1:0]    cc_flag_o,
  output logic                 ovf_flag_o,
  output logic [CW-1:0]        timer_o
);
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_RELOAD = 1;
  localparam int ADDR_CFG0   = 2;
  localparam int ADDR_CMP0   = ADDR_CFG0 + NUM_CH;
  localparam int ADDR_CLR    = 14;
  localparam int ADDR_TMR    = 15;

  logic          run_q, ovf_flag_q, ovf, clr_wr;
  logic [CW-1:0] reload_q, cnt;

  assign clr_wr = wr_en_i && (wr_addr_i == AW'(ADDR_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      reload_q   <= '0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == AW'(ADDR_CTRL))   run_q    <= wr_data_i[0];
      if (wr_en_i && wr_addr_i == AW'(ADDR_RELOAD)) reload_q <= wr_data_i;
      if (ovf)                              ovf_flag_q <= 1'b1;
      else if (clr_wr && wr_data_i[CW-1])   ovf_flag_q <= 1'b0;
    end
  end

  ccu_timebase #(.CW(CW)) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .load_i     (wr_en_i && wr_addr_i == AW'(ADDR_TMR)),
    .load_val_i (wr_data_i),
    .reload_i   (reload_q),
    .cnt_o      (cnt),
    .ovf_o      (ovf)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ccu_channel #(.CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_wr_i   (wr_en_i && wr_addr_i == AW'(ADDR_CFG0 + i)),
      .cfg_data_i (wr_data_i[6:0]),
      .cmp_wr_i   (wr_en_i && wr_addr_i == AW'(ADDR_CMP0 + i)),
      .cmp_data_i (wr_data_i),
      .flag_clr_i (clr_wr && wr_data_i[i]),
      .run_i      (run_q),
      .ovf_i      (ovf),
      .cnt_i      (cnt),
      .pin_i      (cc_pin_i[i]),
      .pin_o      (cc_pin_o[i]),
      .cc_o       (cc_val_o[i*CW +: CW]),
      .flag_o     (cc_flag_o[i])
    );
  end

  assign ovf_flag_o = ovf_flag_q;
  assign timer_o    = cnt;

  assert_ovf_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> ovf_flag_q);
  assert_ovf_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> timer_o == $past(reload_q));
endmodule

// File: tb/reload_ccu_tb.sv
module reload_ccu_tb;
  localparam int NCH = 6;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [3:0]        wr_addr = '0;
  logic [CW-1:0]     wr_data = '0;
  logic [NCH-1:0]    pins = '0;
  logic [NCH-1:0]    pin_o;
  logic [NCH*CW-1:0] val_o;
  logic [NCH-1:0]    flag_o;
  logic              ovf_flag;
  logic [CW-1:0]     timer;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  reload_ccu u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .cc_pin_i   (pins),
    .cc_pin_o   (pin_o),
    .cc_val_o   (val_o),
    .cc_flag_o  (flag_o),
    .ovf_flag_o (ovf_flag),
    .timer_o    (timer)
  );

  function automatic logic [CW-1:0] val(int ch);
    return val_o[ch*CW +: CW];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [CW-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_timer(logic [CW-1:0] v);
    while (timer !== v) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic t_reset();
    chk("R11 timer", timer, 0);
    chk("R11 pins", pin_o, 0);
    chk("R11 flags", flag_o, 0);
    chk("R11 ovf flag", ovf_flag, 0);
    chk("R11 values", (val_o == '0), 1);
  endtask

  task automatic t_count();
    logic [CW-1:0] a;
    repeat (4) @(negedge clk);
    chk("R1 hold while stopped", timer, 0);
    wr(15, 16'h1234);
    chk("R1 direct load", timer, 16'h1234);
    wr(0, 16'h0001);
    a = timer;
    @(negedge clk);
    chk("R1 increment", timer, a + 16'd1);
    @(negedge clk);
    chk("R1 increment again", timer, a + 16'd2);
  endtask

  task automatic t_wrap();
    wr(1, 16'hFFF0);
    wr(15, 16'hFFFD);
    chk("R2 loaded", timer, 16'hFFFD);
    @(negedge clk); chk("R2 seq FFFE", timer, 16'hFFFE);
    @(negedge clk); chk("R2 seq FFFF", timer, 16'hFFFF);
    chk("R2 flag before wrap", ovf_flag, 0);
    @(negedge clk); chk("R2 reload", timer, 16'hFFF0);
    chk("R2 flag set", ovf_flag, 1);
    wr(14, 16'h8000);
    chk("R2 flag cleared", ovf_flag, 0);
  endtask

  task automatic t_compare_hi();
    wr(2, 16'h0021);
    wr(8, 16'hFFF8);
    wait_timer(16'hFFF0);
    for (int i = 0; i < 32; i++) begin
      chk("R3 level1 waveform", pin_o[0], (timer >= 16'hFFF9));
      @(negedge clk);
    end
    chk("R9 match flag", flag_o[0], 1);
    wait_timer(16'hFFF0);
    wr(14, 16'h0001);
    chk("R9 flag cleared", flag_o[0], 0);
  endtask

  task automatic t_compare_lo();
    wr(5, 16'h0001);
    wr(11, 16'hFFF8);
    @(negedge clk);
    wait_timer(16'hFFF0);
    for (int i = 0; i < 32; i++) begin
      chk("R3 level0 waveform", pin_o[3], (timer <= 16'hFFF8));
      @(negedge clk);
    end
  endtask

  task automatic t_shadow();
    wr(3, 16'h0031);
    wait_timer(16'hFFF2);
    wr(9, 16'hFFF4);
    chk("R4 active unchanged", val(1), 0);
    while (timer !== 16'hFFF0) begin
      chk("R4 no early match", pin_o[1], 0);
      @(negedge clk);
    end
    chk("R4 transfer at overflow", val(1), 16'hFFF4);
    for (int i = 0; i < 16; i++) begin
      chk("R4 new value active", pin_o[1], (timer >= 16'hFFF5));
      @(negedge clk);
    end
  endtask

  task automatic t_immediate();
    wr(3, 16'h0021);
    wait_timer(16'hFFF2);
    wr(9, 16'hFFFA);
    chk("R5 immediate value", val(1), 16'hFFFA);
    wait_timer(16'hFFFA);
    chk("R5 before match", pin_o[1], 0);
    @(negedge clk);
    chk("R5 match same period", pin_o[1], 1);
  endtask

  task automatic t_below_reload();
    wr(4, 16'h0001);
    wr(10, 16'h0010);
    wait_timer(16'hFFF0);
    wr(14, 16'h0004);
    for (int i = 0; i < 40; i++) begin
      chk("R6 output at overflow level", pin_o[2], 1);
      chk("R6 no flag", flag_o[2], 0);
      @(negedge clk);
    end
  endtask

  task automatic cap_edge(int ch, logic lvl, logic expect_cap, string tag);
    logic [CW-1:0] t, old;
    old = val(ch);
    @(negedge clk);
    pins[ch] = lvl;
    @(negedge clk);
    @(negedge clk);
    t = timer;
    @(negedge clk);
    chk(tag, val(ch), expect_cap ? t : old);
    chk(tag, flag_o[ch], expect_cap);
  endtask

  task automatic t_capture();
    wr(6, 16'h0006);
    wr(14, 16'h0030);
    cap_edge(4, 1'b1, 1'b1, "R7 rising captured");
    wr(14, 16'h0010);
    cap_edge(4, 1'b0, 1'b0, "R7 falling ignored");
    wr(6, 16'h000A);
    cap_edge(4, 1'b1, 1'b0, "R7 rising ignored");
    cap_edge(4, 1'b0, 1'b1, "R7 falling captured");
    wr(7, 16'h000E);
    cap_edge(5, 1'b1, 1'b1, "R7 both rise");
    wr(14, 16'h0020);
    cap_edge(5, 1'b0, 1'b1, "R7 both fall");
    wr(14, 16'h0010);
    chk("R9 other flag kept", flag_o[5], 1);
    chk("R9 own flag cleared", flag_o[4], 0);
  endtask

  task automatic t_soft_idle();
    logic [CW-1:0] t;
    logic p;
    wr(2, 16'h0000);
    wr(14, 16'h0001);
    @(negedge clk);
    t = timer;
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h0040;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 soft capture value", val(0), t);
    chk("R8 soft capture flag", flag_o[0], 1);
    p = pin_o[0];
    for (int i = 0; i < 24; i++) begin
      chk("R10 idle pin holds", pin_o[0], p);
      @(negedge clk);
    end
    p = pin_o[4];
    for (int i = 0; i < 20; i++) begin
      chk("R10 capture pin holds", pin_o[4], p);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_compare_hi();
    t_compare_lo();
    t_shadow();
    t_immediate();
    t_below_reload();
    t_capture();
    t_soft_idle();
    summary();
    $finish;
  end
endmodule